// File: doc/BRIEF.md
# Staggered Training-Pattern Readout

This block holds four small training patterns and plays them back as fixed-length bursts on a narrow multi-lane data bus. A read names one pattern location. Each lane then sends one pattern serially, most significant bit first, over eight beats. In staggered format every lane starts from a different location: the addressed one is rotated by the lane number. In parallel format all lanes repeat the addressed pattern. A controller that trains its receive path can tell the lanes apart in staggered format. In parallel format it can check lane-to-lane skew on identical data.

A read that arrives while a burst is still playing waits in a single-entry buffer and starts on the very next beat. Reads issued every eight cycles therefore form one unbroken stream. Pattern writes never tear a burst in flight. A write to a location that the running burst reads is held back until no burst reads that location.

Top module: `mpr_stagger_readout`

## Requirements
- R1: After reset, `data_valid` and `overflow` are low, `lane_data` is zero, and the pattern locations 0, 1, 2 and 3 hold 8'h55, 8'h33, 8'h0F and 8'h00.
- R2: Take a read strobe that is sampled while no burst is playing. `data_valid` rises in the next cycle and stays high for exactly 8 cycles. While `data_valid` is low, `lane_data` is all zero.
- R3: On beat k of a burst (k = 0..7), each lane carries bit 7-k of its source pattern, so the most significant bit goes out first.
- R4: When `stagger_mode` = 1, lane i carries the pattern at location (addressed location + i) mod 4.
- R5: When `stagger_mode` = 0, every lane carries the addressed pattern.
- R6: A read sampled while a burst is playing is buffered. Its burst begins in the cycle right after the current burst's last beat. Reads sampled every 8 cycles yield one continuous run of `data_valid`, 8 cycles per read.
- R7: A read sampled while a burst is playing and the buffer is already full is dropped. It produces no beats, and `overflow` is high for exactly the one cycle after that sampling edge.
- R8: A write to a location that no running burst reads takes effect at its sampling edge. A read sampled at any later edge returns the new value.
- R9: A write to a location that the running burst reads leaves that burst's data unchanged. It takes effect once no burst reads the location. A staggered burst reads all four locations, and a parallel burst reads only its addressed one.
- R10: The format is captured per read when the read is sampled. Buffered reads keep their own format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pattern write strobe |
| wr_loc | input | 2 | Location to write |
| wr_data | input | 8 | New pattern value |
| rd_req | input | 1 | Read strobe, one per burst |
| rd_loc | input | 2 | Addressed starting location |
| stagger_mode | input | 1 | 1 = staggered format, 0 = parallel format |
| lane_data | output | 4 | Serial data, one bit per lane |
| data_valid | output | 1 | High while a burst beat is on the lanes |
| overflow | output | 1 | One-cycle pulse when a read is dropped |

## Verification
A beat counter that skips or repeats a value shows up as a wrong bit on some lane within the same burst. It also shows up as a run of `data_valid` that is not a multiple of eight, seen when the run ends. A wrong buffer state shows up one burst later: either a gap in a stream that should be gapless, a spurious extra burst, or a missing `overflow` pulse in the cycle after the dropped read. A write path that ignores a collision corrupts the lane that reads the written location during the burst still in flight.

// File: rtl/mpr_readout_pkg.sv
package mpr_readout_pkg;
  typedef enum logic {
    FMT_PARALLEL = 1'b0,
    FMT_STAGGER  = 1'b1
  } burst_fmt_e;
endpackage

// File: rtl/mpr_burst_seq.sv
module mpr_burst_seq
  import mpr_readout_pkg::*;
#(
  parameter int LOC_W     = 2,
  parameter int BURST_LEN = 8,
  localparam int BEAT_W   = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [LOC_W-1:0]  rd_loc,
  input  burst_fmt_e        rd_fmt,
  output logic              act,
  output logic [BEAT_W-1:0] beat,
  output logic [LOC_W-1:0]  cur_loc,
  output burst_fmt_e        cur_fmt,
  output logic              overflow
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic             q_vld;
  logic [LOC_W-1:0] q_loc;
  burst_fmt_e       q_fmt;
  logic             slot_free;

  // the output slot after this edge is free when idle or on the final beat
  assign slot_free = !act || (beat == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      beat     <= '0;
      cur_loc  <= '0;
      cur_fmt  <= FMT_PARALLEL;
      q_vld    <= 1'b0;
      q_loc    <= '0;
      q_fmt    <= FMT_PARALLEL;
      overflow <= 1'b0;
    end else begin
      overflow <= 1'b0;
      if (slot_free) begin
        if (q_vld) begin
          act     <= 1'b1;
          beat    <= '0;
          cur_loc <= q_loc;
          cur_fmt <= q_fmt;
          q_vld   <= rd_req;
          if (rd_req) begin
            q_loc <= rd_loc;
            q_fmt <= rd_fmt;
          end
        end else if (rd_req) begin
          act     <= 1'b1;
          beat    <= '0;
          cur_loc <= rd_loc;
          cur_fmt <= rd_fmt;
        end else begin
          act  <= 1'b0;
          beat <= '0;
        end
      end else begin
        beat <= beat + 1'b1;
        if (rd_req) begin
          if (!q_vld) begin
            q_vld <= 1'b1;
            q_loc <= rd_loc;
            q_fmt <= rd_fmt;
          end else begin
            overflow <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mpr_pattern_store.sv
module mpr_pattern_store
  import mpr_readout_pkg::*;
#(
  parameter int LOCS  = 4,
  parameter int PAT_W = 8,
  parameter logic [LOCS*PAT_W-1:0] PAT_INIT = '0,
  localparam int LOC_W = $clog2(LOCS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [LOC_W-1:0]           wr_loc,
  input  logic [PAT_W-1:0]           wr_data,
  input  logic                       busy,
  input  logic [LOC_W-1:0]           busy_loc,
  input  burst_fmt_e                 busy_fmt,
  output logic [LOCS-1:0][PAT_W-1:0] pats
);
  localparam logic [LOCS-1:0][PAT_W-1:0] INIT_ARR = PAT_INIT;

  logic [LOCS-1:0][PAT_W-1:0] pend_dat;
  logic [LOCS-1:0]            pend_vld;

  for (genvar l = 0; l < LOCS; l++) begin : g_loc
    logic in_use;
    logic hit;
    assign in_use = busy && ((busy_fmt == FMT_STAGGER) || (busy_loc == LOC_W'(l)));
    assign hit    = wr_en && (wr_loc == LOC_W'(l));

    always_ff @(posedge clk) begin
      if (rst) begin
        pats[l]     <= INIT_ARR[l];
        pend_dat[l] <= '0;
        pend_vld[l] <= 1'b0;
      end else if (hit) begin
        if (in_use) begin
          pend_dat[l] <= wr_data;
          pend_vld[l] <= 1'b1;
        end else begin
          pats[l]     <= wr_data;
          pend_vld[l] <= 1'b0;
        end
      end else if (pend_vld[l] && !in_use) begin
        pats[l]     <= pend_dat[l];
        pend_vld[l] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpr_lane_mux.sv
module mpr_lane_mux
  import mpr_readout_pkg::*;
#(
  parameter int LOCS  = 4,
  parameter int PAT_W = 8,
  parameter int LANES = 4,
  localparam int LOC_W  = $clog2(LOCS),
  localparam int BEAT_W = $clog2(PAT_W)
) (
  input  logic [LOCS-1:0][PAT_W-1:0] pats,
  input  logic                       act,
  input  logic [BEAT_W-1:0]          beat,
  input  logic [LOC_W-1:0]           cur_loc,
  input  burst_fmt_e                 cur_fmt,
  output logic [LANES-1:0]           lane_data
);
  logic [BEAT_W-1:0] bit_idx;
  assign bit_idx = BEAT_W'(PAT_W - 1) - beat;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LOC_W-1:0] src;
    // rotation wraps naturally because LOCS is a power of two
    assign src          = (cur_fmt == FMT_STAGGER) ? cur_loc + LOC_W'(i) : cur_loc;
    assign lane_data[i] = act & pats[src][bit_idx];
  end
endmodule

// File: rtl/mpr_stagger_readout.sv
module mpr_stagger_readout
  import mpr_readout_pkg::*;
#(
  parameter int LOCS  = 4,
  parameter int PAT_W = 8,
  parameter int LANES = 4,
  parameter logic [LOCS*PAT_W-1:0] PAT_INIT = 32'h000F_3355,
  localparam int LOC_W  = $clog2(LOCS),
  localparam int BEAT_W = $clog2(PAT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic [PAT_W-1:0]  wr_data,
  input  logic              rd_req,
  input  logic [LOC_W-1:0]  rd_loc,
  input  logic              stagger_mode,
  output logic [LANES-1:0]  lane_data,
  output logic              data_valid,
  output logic              overflow
);
  logic                       act;
  logic [BEAT_W-1:0]          beat;
  logic [LOC_W-1:0]           cur_loc;
  burst_fmt_e                 cur_fmt;
  burst_fmt_e                 rd_fmt;
  logic [LOCS-1:0][PAT_W-1:0] pats;
  logic                       burst_stag;

  assign rd_fmt     = stagger_mode ? FMT_STAGGER : FMT_PARALLEL;
  assign burst_stag = (cur_fmt == FMT_STAGGER);
  assign data_valid = act;

  mpr_burst_seq #(.LOC_W(LOC_W), .BURST_LEN(PAT_W)) u_seq (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_loc(rd_loc), .rd_fmt(rd_fmt),
    .act(act), .beat(beat), .cur_loc(cur_loc), .cur_fmt(cur_fmt),
    .overflow(overflow)
  );

  mpr_pattern_store #(.LOCS(LOCS), .PAT_W(PAT_W), .PAT_INIT(PAT_INIT)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data),
    .busy(act), .busy_loc(cur_loc), .busy_fmt(cur_fmt), .pats(pats)
  );

  mpr_lane_mux #(.LOCS(LOCS), .PAT_W(PAT_W), .LANES(LANES)) u_mux (
    .pats(pats), .act(act), .beat(beat), .cur_loc(cur_loc), .cur_fmt(cur_fmt),
    .lane_data(lane_data)
  );
endmodule

// File: rtl/mpr_readout_checker.sv
module mpr_readout_checker #(
  parameter int LANES = 4,
  parameter int PAT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_req,
  input logic             data_valid,
  input logic             overflow,
  input logic [LANES-1:0] lane_data,
  input logic             burst_stag
);
  logic        rst_q;
  logic [15:0] run;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q && !rst) begin
      assert_reset_idle_R1: assert (!data_valid && !overflow && lane_data == '0)
        else $error("R1: outputs not idle after reset");
    end
    if (rst) begin
      run <= '0;
    end else if (data_valid) begin
      run <= run + 16'd1;
    end else begin
      if (run != '0) begin
        assert_whole_bursts_R2: assert ((run % PAT_W) == 0)
          else $error("R2: valid run of %0d is not whole bursts", run);
      end
      run <= '0;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> lane_data == '0);

  assert_drop_only_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(rd_req) && $past(data_valid)));

  assert_parallel_lanes_agree_R5: assert property (@(posedge clk) disable iff (rst)
    (data_valid && !burst_stag) |-> (lane_data == '0 || lane_data == '1));
endmodule

bind mpr_stagger_readout mpr_readout_checker #(.LANES(LANES), .PAT_W(PAT_W)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .data_valid(data_valid),
  .overflow(overflow), .lane_data(lane_data), .burst_stag(burst_stag)
);

// File: tb/tb_mpr_stagger_readout.sv
module tb_mpr_stagger_readout;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_loc = '0;
  logic [7:0] wr_data = '0;
  logic       rd_req = 1'b0;
  logic [1:0] rd_loc = '0;
  logic       stagger_mode = 1'b0;
  logic [3:0] lane_data;
  logic       data_valid;
  logic       overflow;

  int checks = 0;
  int failures = 0;
  int run = 0;
  int last_run = 0;
  bit done = 0;

  logic [7:0] mp [4];
  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  mpr_stagger_readout dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data),
    .rd_req(rd_req), .rd_loc(rd_loc), .stagger_mode(stagger_mode),
    .lane_data(lane_data), .data_valid(data_valid), .overflow(overflow)
  );

  task automatic chk(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // pushes the 8 expected beats computed from the model patterns
  task automatic push_read(int loc, bit stag, string tag);
    for (int k = 0; k < 8; k++) begin
      logic [3:0] l;
      for (int i = 0; i < 4; i++) l[i] = mp[stag ? (loc + i) % 4 : loc][7 - k];
      exp_q.push_back(l);
      tag_q.push_back(tag);
    end
  endtask

  // called just after a rising edge; the read is sampled at the next edge
  task automatic issue(int loc, bit stag, bit expect_beats, string tag);
    rd_req = 1'b1;
    rd_loc = loc[1:0];
    stagger_mode = stag;
    if (expect_beats) push_read(loc, stag, tag);
    @(posedge clk);
    #1;
    rd_req = 1'b0;
  endtask

  task automatic write_pat(int loc, logic [7:0] d);
    wr_en = 1'b1;
    wr_loc = loc[1:0];
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (data_valid) begin
        run++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R7 unexpected beat", lane_data, 0);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(lane_data === e, t, lane_data, e);
        end
      end else begin
        chk(lane_data === 4'h0, "R2 idle lanes", lane_data, 0);
        if (run != 0) begin
          last_run = run;
          run = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    mp[0] = 8'h55; mp[1] = 8'h33; mp[2] = 8'h0F; mp[3] = 8'h00;
    idle(3);
    @(negedge clk);
    chk(data_valid === 1'b0, "R1 valid", data_valid, 0);
    chk(overflow === 1'b0, "R1 overflow", overflow, 0);
    chk(lane_data === 4'h0, "R1 lanes", lane_data, 0);
    rst = 1'b0;
    idle(1);

    // R1 defaults, R3 bit order, R4 rotation from location 0
    issue(0, 1, 1, "R1/R3/R4 stagger loc0");
    @(negedge clk);
    chk(data_valid === 1'b1, "R2 valid rises next cycle", data_valid, 1);
    idle(12);
    chk(last_run == 8, "R2 burst length", last_run, 8);

    issue(3, 1, 1, "R4 stagger loc3");
    idle(12);
    issue(1, 0, 1, "R5 parallel loc1");
    idle(12);
    chk(last_run == 8, "R5 burst length", last_run, 8);

    // R6 seamless stream 0,1,2,3,0,1,2,3
    for (int r = 0; r < 8; r++) begin
      issue(r % 4, 1, 1, "R6 stream");
      if (r != 7) idle(7);
    end
    idle(12);
    chk(last_run == 64, "R6 continuous run", last_run, 64);

    // R6 buffered read, R7 dropped read, R10 per-read format
    issue(2, 1, 1, "R6 first of pair");
    idle(1);
    issue(1, 0, 1, "R10 buffered parallel");
    @(negedge clk);
    chk(overflow === 1'b0, "R7 no overflow on buffered read", overflow, 0);
    #3;
    issue(0, 1, 0, "R7 dropped");
    @(negedge clk);
    chk(overflow === 1'b1, "R7 overflow pulse", overflow, 1);
    @(negedge clk);
    chk(overflow === 1'b0, "R7 overflow one cycle", overflow, 0);
    idle(20);
    chk(last_run == 16, "R6/R7 buffered run only", last_run, 16);

    // R8 write to idle location
    write_pat(3, 8'hA5);
    mp[3] = 8'hA5;
    issue(3, 0, 1, "R8 write visible");
    idle(12);

    // R9 collision with staggered burst: lane 2 keeps old 0F
    issue(0, 1, 1, "R9 old data kept");
    idle(2);
    write_pat(2, 8'hC3);
    idle(12);
    mp[2] = 8'hC3;
    issue(2, 1, 1, "R9 deferred write landed");
    idle(12);

    // R8/R9 with a parallel burst: other location immediate, same one deferred
    issue(1, 0, 1, "R9 parallel old data");
    write_pat(0, 8'h3C);
    mp[0] = 8'h3C;
    write_pat(1, 8'h99);
    idle(1);
    issue(0, 0, 1, "R8 write during other-location burst");
    idle(14);
    mp[1] = 8'h99;
    issue(1, 0, 1, "R9 parallel deferred write");
    idle(14);

    chk(exp_q.size() == 0, "R2 all expected beats seen", exp_q.size(), 0);
    finish_run();
  end
endmodule